// File: doc/BRIEF.md
# Multiview Register Bank

This block is a small register bank on a plain synchronous bus. The bus has an address, a write enable with write data, and a read enable. Read data comes back one cycle later. Two of its locations do not behave like ordinary storage.

The first location is a flag/command location. A read returns two status flags. A write is decoded as a set of command bits that set and clear those flags and fire a one-cycle start strobe. The second location holds arguments. Its readable layout follows the operation code held in a third register. That code selects a one-byte view, a two-byte view or no access. All three cases sit over a single 16-bit store, and every write updates that store whatever the operation code is.

A host uses the bank in three steps. It programs the operation code, writes the arguments and fires the start command. A separate engine reports completion through a done pulse, which the host then acknowledges with a clear command.

Top module: `mvr_bank`

## Requirements
- R1: After reset, VALID and DONE are 0, the operation code is 0 (NOP), the argument store is 0 and startPulse is low. Reads of every mapped address then return 0.
- R2: A read of address 0x0 returns VALID in bit 1 and DONE in bit 0, with all other bits 0. The data appears on busRdData in the cycle after busRdEn is sampled. busRdData is 0 in any cycle that does not follow a read.
- R3: A write to 0x0 with bit 3 set sets VALID, and with bit 2 set clears VALID. If both bits are set, VALID is cleared.
- R4: A write to 0x0 with bit 1 set clears DONE. A high doneIn sets DONE. When both happen in the same cycle, DONE ends up set.
- R5: A write to 0x0 with bit 0 set drives startPulse high for exactly the one cycle after the write. A later read of 0x0 never shows this bit.
- R6: Address 0x8 holds a 3-bit operation code in bits [2:0] that reads back as written. The codes are NOP=0, INC=1, DEC=2, ADD=3 and SUB=4.
- R7: A write to 0x4 stores bits [15:0] of the write data under any operation code, NOP included.
- R8: With INC or DEC selected, a read of 0x4 returns the stored bits [7:0] in bits [7:0]. All higher bits read as 0.
- R9: With ADD or SUB selected, a read of 0x4 returns the first argument in bits [15:8] and the second argument in bits [7:0], both taken from the same store.
- R10: With code 0 or codes 5 to 7 selected, a read of 0x4 returns 0.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Registered read data, one cycle after busRdEn |
| doneIn | input | 1 | One-cycle completion pulse that sets DONE |
| startPulse | output | 1 | One-cycle start strobe produced by the start command |

## Verification
Two actions can hit DONE in the same clock edge: the external done pulse sets it and a clear-done command write clears it. The bench raises doneIn in the same cycle as a write of the clear-done bit. It then reads the flag location and expects DONE to still be 1. A second pair that can collide is the set and clear bits of VALID within one write word. That case is driven as a single write with both bits set and is judged by a status read showing VALID at 0.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_INC = 3'd1,
    OP_DEC = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4
  } opCode_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STAT,
    RD_ARG,
    RD_OP
  } rdSel_e;

  typedef struct packed {
    logic   wrCmd;
    logic   wrArg;
    logic   wrOp;
    rdSel_e rdSel;
  } busStrobe_t;

  // command bit positions of a write to the flag location
  localparam int CMD_SETV  = 3;
  localparam int CMD_CLRV  = 2;
  localparam int CMD_CLRD  = 1;
  localparam int CMD_START = 0;

  // status bit positions of a read from the flag location
  localparam int STAT_VALID = 1;
  localparam int STAT_DONE  = 0;

endpackage

// File: rtl/mvr_ctrl.sv
module mvr_ctrl
  import mvr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_ADDR = 'h0,
  parameter int ARG_ADDR  = 'h4,
  parameter int OP_ADDR   = 'h8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] ARG_A  = ADDR_W'(ARG_ADDR);
  localparam logic [ADDR_W-1:0] OP_A   = ADDR_W'(OP_ADDR);

  logic hitStat, hitArg, hitOp;

  always_comb begin
    hitStat = (busAddr == STAT_A);
    hitArg  = (busAddr == ARG_A);
    hitOp   = (busAddr == OP_A);

    strobe.wrCmd = busWrEn && hitStat;
    strobe.wrArg = busWrEn && hitArg;
    strobe.wrOp  = busWrEn && hitOp;

    strobe.rdSel = RD_NONE;
    if (busRdEn) begin
      if (hitStat)     strobe.rdSel = RD_STAT;
      else if (hitArg) strobe.rdSel = RD_ARG;
      else if (hitOp)  strobe.rdSel = RD_OP;
    end
  end

endmodule

// File: rtl/mvr_datapath.sv
module mvr_datapath
  import mvr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ARG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              doneIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              startPulse,
  output logic              validQ,
  output logic              doneQ,
  output logic [OP_W-1:0]   opQ
);

  localparam int STORE_W = 2 * ARG_W;

  logic [STORE_W-1:0] argStore;
  logic [DATA_W-1:0]  rdNext;
  logic [DATA_W-1:0]  argView;

  // flag and strobe state driven by command writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ     <= 1'b0;
      doneQ      <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= strobe.wrCmd && busWrData[CMD_START];
      if (strobe.wrCmd && busWrData[CMD_CLRV])      validQ <= 1'b0;
      else if (strobe.wrCmd && busWrData[CMD_SETV]) validQ <= 1'b1;
      if (doneIn)                                   doneQ <= 1'b1;
      else if (strobe.wrCmd && busWrData[CMD_CLRD]) doneQ <= 1'b0;
    end
  end

  // operation code and shared argument storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ      <= OP_NOP;
      argStore <= '0;
    end else begin
      if (strobe.wrOp)  opQ      <= busWrData[OP_W-1:0];
      if (strobe.wrArg) argStore <= busWrData[STORE_W-1:0];
    end
  end

  // view of the argument store chosen by the operation code
  always_comb begin
    argView = '0;
    case (opQ)
      OP_INC, OP_DEC: argView[ARG_W-1:0]   = argStore[ARG_W-1:0];
      OP_ADD, OP_SUB: argView[STORE_W-1:0] = argStore;
      default:        argView              = '0;
    endcase
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      RD_STAT: begin
        rdNext[STAT_VALID] = validQ;
        rdNext[STAT_DONE]  = doneQ;
      end
      RD_ARG:  rdNext = argView;
      RD_OP:   rdNext[OP_W-1:0] = opQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= rdNext;
  end

endmodule

// File: rtl/mvr_bank.sv
module mvr_bank
  import mvr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ARG_W     = 8,
  parameter int STAT_ADDR = 'h0,
  parameter int ARG_ADDR  = 'h4,
  parameter int OP_ADDR   = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              doneIn,
  output logic              startPulse
);

  busStrobe_t            strobe;
  logic                  validQ;
  logic                  doneQ;
  logic [OP_W-1:0]       opQ;

  mvr_ctrl #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .ARG_ADDR (ARG_ADDR),
    .OP_ADDR  (OP_ADDR)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  mvr_datapath #(
    .DATA_W(DATA_W),
    .ARG_W (ARG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .doneIn    (doneIn),
    .busRdData (busRdData),
    .startPulse(startPulse),
    .validQ    (validQ),
    .doneQ     (doneQ),
    .opQ       (opQ)
  );

endmodule

// File: rtl/mvr_checker.sv
module mvr_checker
  import mvr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ARG_W     = 8,
  parameter int STAT_ADDR = 'h0,
  parameter int ARG_ADDR  = 'h4,
  parameter int OP_ADDR   = 'h8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              doneIn,
  input logic              startPulse,
  input logic              validQ,
  input logic              doneQ,
  input logic [OP_W-1:0]   opQ
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] ARG_A  = ADDR_W'(ARG_ADDR);
  localparam logic [ADDR_W-1:0] OP_A   = ADDR_W'(OP_ADDR);

  logic cmdWr, argRd, mappedRd, nopSel, unarySel;
  assign cmdWr    = busWrEn && (busAddr == STAT_A);
  assign argRd    = busRdEn && (busAddr == ARG_A);
  assign mappedRd = (busAddr == STAT_A) || (busAddr == ARG_A) || (busAddr == OP_A);
  assign nopSel   = (opQ == 3'd0) || (opQ > 3'd4);
  assign unarySel = (opQ == 3'd1) || (opQ == 3'd2);

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(busRdEn) |-> busRdData == '0);

  assert_clr_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(cmdWr && busWrData[CMD_CLRV]) |-> !validQ);

  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(doneIn) |-> doneQ);

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> startPulse == $past(cmdWr && busWrData[CMD_START]));

  assert_unary_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(argRd && unarySel) |-> busRdData[DATA_W-1:ARG_W] == '0);

  assert_nop_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(argRd && nopSel) |-> busRdData == '0);

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(busRdEn && !mappedRd) |-> busRdData == '0);

endmodule

bind mvr_bank mvr_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ARG_W    (ARG_W),
  .STAT_ADDR(STAT_ADDR),
  .ARG_ADDR (ARG_ADDR),
  .OP_ADDR  (OP_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .doneIn    (doneIn),
  .startPulse(startPulse),
  .validQ    (validQ),
  .doneQ     (doneQ),
  .opQ       (opQ)
);

// File: tb/sim_mvr_bank.sv
module sim_mvr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busRdData;
  logic              doneIn = 1'b0;
  logic              startPulse;

  int nChecks = 0;
  int nFails  = 0;
  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mvr_bank u0 (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .doneIn    (doneIn),
    .startPulse(startPulse)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver tasks: entered and left at a falling edge
  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                         input string tag);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // monitor: compares registered read data against queued expectations
  initial begin
    forever begin
      logic pend;
      @(posedge clk);
      pend = busRdEn;
      @(negedge clk);
      if (pend) begin
        if (expQ.size() == 0) check("monitor underflow", 32'h1, 32'h0);
        else check(tagQ.pop_front(), busRdData, expQ.pop_front());
      end else if (rstN) begin
        check("R2 idle read data", busRdData, '0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 startPulse after reset", {31'b0, startPulse}, 32'h0);
    busRead(8'h0, 32'h0, "R1 status reset");
    busRead(8'h4, 32'h0, "R1 arg reset");
    busRead(8'h8, 32'h0, "R1 op reset");

    // VALID set/clear
    busWrite(8'h0, 32'h8);
    busRead(8'h0, 32'h2, "R3 set VALID");
    busWrite(8'h0, 32'hC);
    busRead(8'h0, 32'h0, "R3 clear wins over set");
    busWrite(8'h0, 32'h8);
    busWrite(8'h0, 32'h4);
    busRead(8'h0, 32'h0, "R3 clear VALID");

    // DONE set/clear and collision
    doneIn = 1'b1; @(negedge clk); doneIn = 1'b0;
    busRead(8'h0, 32'h1, "R4 doneIn sets DONE");
    busWrite(8'h0, 32'h2);
    busRead(8'h0, 32'h0, "R4 clear DONE");
    doneIn = 1'b1;
    busWrite(8'h0, 32'h2);
    doneIn = 1'b0;
    busRead(8'h0, 32'h1, "R4 done pulse beats clear");
    busWrite(8'h0, 32'h2);
    busRead(8'h0, 32'h0, "R4 clear again");

    // start strobe
    busWrite(8'h0, 32'h1);
    check("R5 startPulse high", {31'b0, startPulse}, 32'h1);
    @(negedge clk);
    check("R5 startPulse one cycle", {31'b0, startPulse}, 32'h0);
    busRead(8'h0, 32'h0, "R5 start not readable");

    // operation code and argument views
    busWrite(8'h8, 32'h3);
    busRead(8'h8, 32'h3, "R6 op readback");
    busWrite(8'h4, 32'hFFFF_A5C3);
    busRead(8'h4, 32'h0000_A5C3, "R9 ADD binary view");
    busWrite(8'h8, 32'h4);
    busRead(8'h4, 32'h0000_A5C3, "R9 SUB binary view");
    busWrite(8'h8, 32'h1);
    busRead(8'h4, 32'h0000_00C3, "R8 INC unary view");
    busWrite(8'h8, 32'h2);
    busRead(8'h4, 32'h0000_00C3, "R8 DEC unary view");
    busWrite(8'h8, 32'h0);
    busRead(8'h4, 32'h0, "R10 NOP reads zero");
    busWrite(8'h4, 32'h0000_1234);
    busWrite(8'h8, 32'h3);
    busRead(8'h4, 32'h0000_1234, "R7 write under NOP stored");
    busWrite(8'h8, 32'h5);
    busRead(8'h4, 32'h0, "R10 code 5 reads zero");
    busWrite(8'h8, 32'h7);
    busRead(8'h4, 32'h0, "R10 code 7 reads zero");
    busRead(8'h8, 32'h7, "R6 raw code readback");

    // unmapped accesses
    busWrite(8'h8, 32'h3);
    busWrite(8'h0, 32'h8);
    busRead(8'hC, 32'h0, "R11 unmapped read");
    busWrite(8'hC, 32'hFFFF_FFFF);
    busWrite(8'h10, 32'h0000_000F);
    busWrite(8'h5, 32'h0000_0004);
    busRead(8'h0, 32'h2, "R11 status unchanged");
    busRead(8'h4, 32'h0000_1234, "R11 arg unchanged");
    busRead(8'h8, 32'h3, "R11 op unchanged");

    repeat (3) @(negedge clk);
    check("queue drained", 32'(expQ.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule